// File: doc/BRIEF.md
# PCI Interrupt Summary and Mask Register

This block gathers nineteen level-sensitive interrupt request lines and presents them to the processor through three byte-wide registers on a simple 8-bit I/O port. Sixteen of the lines come from four PCI slots, with four request pins per slot. The other three come from the legacy bridge cascade, the IDE controller and the USB controller. Each line has its own mask bit. The block drives one combined interrupt output that is high while any line is active and unmasked.

Software treats the three registers as one 24-bit word, with the lowest address holding the least significant byte. A write stores a mask byte, and the mask cannot be read back. A read returns the live state of the request lines as seen after synchronization, whatever the mask holds. The service routine therefore reads the word to find the pending sources and writes the word to enable or disable them. Priority, vectoring, the legacy cascade controller and the mapping of slots to IRQ numbers all live outside this block.

Top module: `pci_irq_aggregator`

## Requirements
- R1: After reset every mask bit is 1, so all sources are disabled, and `cpuIrq` is 0 even when every request line is high.
- R2: Only the three addresses `BASE_ADDR`, `BASE_ADDR+1` and `BASE_ADDR+2` (default 0x804 to 0x806) are decoded. A write to any other address changes no mask bit, and a read of any other address returns 0.
- R3: A write to `BASE_ADDR+n` loads `ioWrData` into mask byte n on the next clock edge and leaves the other two mask bytes unchanged. A mask bit of 1 disables its source and a 0 enables it.
- R4: A read of `BASE_ADDR+n` returns byte n of the synchronized raw request word during the same cycle. The mask has no effect on the returned value, and the mask itself is never returned.
- R5: Byte 0 layout: bits 0 to 3 are pin A of slots 0 to 3, bit 4 is the bridge cascade, bit 5 is IDE, bit 6 is USB, and bit 7 is pin B of slot 0.
- R6: Byte 1 layout: bits 0 to 2 are pin B of slots 1 to 3, bits 3 to 6 are pin C of slots 0 to 3, and bit 7 is pin D of slot 0.
- R7: Byte 2 layout: bits 0 to 2 are pin D of slots 1 to 3. Bits 3 to 7 always read 0, and the values written to them have no effect on `cpuIrq`.
- R8: `cpuIrq` is a register holding the OR over all sources of (raw AND NOT mask). It follows a mask write one clock edge after the edge that stores the mask.
- R9: Each request input passes through two synchronizer flops. A change on an input shows in the readback after two clock edges, not after one, and shows on `cpuIrq` after three clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| slotIntA | input | 4 | Request pin A of slots 0 to 3 |
| slotIntB | input | 4 | Request pin B of slots 0 to 3 |
| slotIntC | input | 4 | Request pin C of slots 0 to 3 |
| slotIntD | input | 4 | Request pin D of slots 0 to 3 |
| bridgeIrq | input | 1 | Legacy bridge cascade request |
| ideIrq | input | 1 | IDE controller request |
| usbIrq | input | 1 | USB controller request |
| ioAddr | input | ADDR_W | I/O address |
| ioRd | input | 1 | Read strobe |
| ioWr | input | 1 | Write strobe |
| ioWrData | input | 8 | Write data (mask byte) |
| ioRdData | output | 8 | Read data (raw request byte), 0 when no register is selected |
| cpuIrq | output | 1 | Combined interrupt to the processor |

## Verification
The bench walks a single active source through all nineteen positions. A design with the bit layout scrambled would show the bit at the wrong place, and the pin B and pin D bits that cross byte boundaries are the most likely to go wrong. It measures edge by edge how long a request takes to reach the readback and the interrupt output, and how long a mask write takes to reach the output. A synchronizer with one stage missing, or an output that is not registered, would show up one cycle early. Writes with ones and zeros in the reserved positions, and accesses just outside the three-address window, check that reserved bits and neighbouring addresses are never decoded. Randomized rounds with all sources active and partial masks check that a read returns the raw state rather than the masked one, and that the output matches the enabled set.

// File: rtl/pciirq_pkg.sv
package pciirq_pkg;
  localparam int NUM_PORTS      = 3;
  localparam int BYTE_W         = 8;
  localparam int WORD_W         = NUM_PORTS * BYTE_W;
  localparam int NUM_SLOTS      = 4;
  localparam int PINS_PER_SLOT  = 4;
  localparam int NUM_SLOT_LINES = NUM_SLOTS * PINS_PER_SLOT;
  localparam int NUM_ONBOARD    = 3;
  localparam int NUM_SRC        = NUM_SLOT_LINES + NUM_ONBOARD;
  // Word position of the first on-board source (bridge, then IDE, then USB).
  localparam int POS_ONBOARD    = NUM_SLOTS;
  // Word position of pin B of slot 0; pins B, C, D follow in slot order.
  localparam int POS_PIN_B      = NUM_SLOTS + NUM_ONBOARD;
  localparam logic [WORD_W-1:0] LIVE_BITS = WORD_W'((64'd1 << NUM_SRC) - 64'd1);

  typedef struct packed {
    logic [NUM_PORTS-1:0] wrSel;
    logic [NUM_PORTS-1:0] rdSel;
  } ioStrobe_t;

  // Source index: pin * NUM_SLOTS + slot for slot pins, then bridge, IDE, USB.
  function automatic int wordPos(input int src);
    int pin;
    int slot;
    if (src < NUM_SLOT_LINES) begin
      pin  = src / NUM_SLOTS;
      slot = src % NUM_SLOTS;
      if (pin == 0) return slot;
      return POS_PIN_B + (pin - 1) * NUM_SLOTS + slot;
    end
    return POS_ONBOARD + (src - NUM_SLOT_LINES);
  endfunction
endpackage

// File: rtl/pciirq_sync.sv
module pciirq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [STAGES-1:0][W-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= '0;
    else begin
      stageQ[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] warmQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) warmQ <= 2'd0;
        else if (warmQ != 2'd2) warmQ <= warmQ + 2'd1;
      end
      // R9: output equals the input sampled two edges earlier
      assert_sync_depth_R9: assert property (@(posedge clk) disable iff (!rstN)
        (warmQ == 2'd2) |-> (syncOut == $past(asyncIn, 2)));
    end
  endgenerate
endmodule

// File: rtl/pciirq_ctrl.sv
module pciirq_ctrl
  import pciirq_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0804
) (
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  output ioStrobe_t         strobe
);
  logic [NUM_PORTS-1:0] addrHit;

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
      localparam logic [ADDR_W-1:0] PORT_ADDR = BASE_ADDR + ADDR_W'(p);
      assign addrHit[p]      = (ioAddr == PORT_ADDR);
      assign strobe.wrSel[p] = ioWr & addrHit[p];
      assign strobe.rdSel[p] = ioRd & addrHit[p];
    end
  endgenerate
endmodule

// File: rtl/pciirq_dpath.sv
module pciirq_dpath
  import pciirq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ioStrobe_t          strobe,
  input  logic [BYTE_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcSync,
  output logic [BYTE_W-1:0]  rdData,
  output logic               cpuIrq
);
  logic [WORD_W-1:0] rawWord;
  logic [WORD_W-1:0] maskWord;
  logic [NUM_PORTS-1:0][BYTE_W-1:0] maskByte;

  // Scatter sources into the software-visible word
  generate
    for (genvar src = 0; src < NUM_SRC; src++) begin : g_place
      assign rawWord[wordPos(src)] = srcSync[src];
    end
    for (genvar b = NUM_SRC; b < WORD_W; b++) begin : g_rsvd
      assign rawWord[b] = 1'b0;
    end
  endgenerate

  // Mask bytes; positions without a source stay at 1
  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mask
      localparam logic [BYTE_W-1:0] LIVE_BYTE = LIVE_BITS[p*BYTE_W +: BYTE_W];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) maskByte[p] <= '1;
        else if (strobe.wrSel[p]) maskByte[p] <= wrData | ~LIVE_BYTE;
      end
      assign maskWord[p*BYTE_W +: BYTE_W] = maskByte[p];

      // R3: a write lands in its own byte on the next edge
      assert_mask_write_R3: assert property (@(posedge clk) disable iff (!rstN)
        strobe.wrSel[p] |=> (maskByte[p][NUM_SRC > (p+1)*BYTE_W ? BYTE_W-1 : (NUM_SRC-1-p*BYTE_W)]
                             == $past(wrData[NUM_SRC > (p+1)*BYTE_W ? BYTE_W-1 : (NUM_SRC-1-p*BYTE_W)])));
    end
  endgenerate

  // Readback of the raw state of the selected byte
  always_comb begin
    rdData = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (strobe.rdSel[p]) rdData = rdData | rawWord[p*BYTE_W +: BYTE_W];
  end

  // Registered OR reduction of the enabled, active sources
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cpuIrq <= 1'b0;
    else       cpuIrq <= |(rawWord & ~maskWord & LIVE_BITS);
  end

  // R2: at most one register selected per access type
  assert_wr_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.wrSel));
  assert_rd_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.rdSel));
  // R3: no write strobe, no mask change
  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(|strobe.wrSel) |=> $stable(maskWord));
  // R8: output only rises for an enabled active source
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> $past(|(rawWord & ~maskWord & LIVE_BITS)));
  // R7: reserved readback positions are zero
  assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdSel[NUM_PORTS-1] |-> (rdData[BYTE_W-1:NUM_SRC-(NUM_PORTS-1)*BYTE_W] == '0));
endmodule

// File: rtl/pci_irq_aggregator.sv
module pci_irq_aggregator
  import pciirq_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0804,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        slotIntA,
  input  logic [3:0]        slotIntB,
  input  logic [3:0]        slotIntC,
  input  logic [3:0]        slotIntD,
  input  logic              bridgeIrq,
  input  logic              ideIrq,
  input  logic              usbIrq,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic [7:0]        ioWrData,
  output logic [7:0]        ioRdData,
  output logic              cpuIrq
);
  logic [NUM_SRC-1:0] srcAsync;
  logic [NUM_SRC-1:0] srcSync;
  ioStrobe_t          strobe;

  assign srcAsync = {usbIrq, ideIrq, bridgeIrq, slotIntD, slotIntC, slotIntB, slotIntA};

  pciirq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(srcAsync), .syncOut(srcSync)
  );

  pciirq_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr), .strobe(strobe)
  );

  pciirq_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(ioWrData),
    .srcSync(srcSync), .rdData(ioRdData), .cpuIrq(cpuIrq)
  );
endmodule

// File: tb/pci_irq_aggregator_tb.sv
module pci_irq_aggregator_tb;
  localparam logic [15:0] BASE = 16'h0804;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] slotIntA = '0, slotIntB = '0, slotIntC = '0, slotIntD = '0;
  logic bridgeIrq = 1'b0, ideIrq = 1'b0, usbIrq = 1'b0;
  logic [15:0] ioAddr = '0;
  logic ioRd = 1'b0, ioWr = 1'b0;
  logic [7:0] ioWrData = '0;
  logic [7:0] ioRdData;
  logic cpuIrq;

  int checks = 0;
  int errors = 0;
  logic [23:0] modelMask = '1;
  logic [18:0] curSrc = '0;

  always #10 clk = ~clk;

  pci_irq_aggregator u_dut (
    .clk(clk), .rstN(rstN), .slotIntA(slotIntA), .slotIntB(slotIntB),
    .slotIntC(slotIntC), .slotIntD(slotIntD), .bridgeIrq(bridgeIrq),
    .ideIrq(ideIrq), .usbIrq(usbIrq), .ioAddr(ioAddr), .ioRd(ioRd),
    .ioWr(ioWr), .ioWrData(ioWrData), .ioRdData(ioRdData), .cpuIrq(cpuIrq)
  );

  // Source vector order: A[3:0], B[3:0], C[3:0], D[3:0], bridge, IDE, USB
  function automatic int bitOf(input int src);
    int slot = src % 4;
    case (src / 4)
      0: return slot;
      1: return (slot == 0) ? 7 : 7 + slot;
      2: return 11 + slot;
      3: return 15 + slot;
      default: return 4 + (src - 16);
    endcase
  endfunction

  function automatic logic [23:0] expWord(input logic [18:0] v);
    logic [23:0] w = '0;
    for (int i = 0; i < 19; i++) w[bitOf(i)] = v[i];
    return w;
  endfunction

  function automatic logic expIrq(input logic [18:0] v, input logic [23:0] m);
    return |(expWord(v) & ~m & 24'h07FFFF);
  endfunction

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setSrc(input logic [18:0] v);
    curSrc = v;
    {usbIrq, ideIrq, bridgeIrq, slotIntD, slotIntC, slotIntB, slotIntA} = v;
  endtask

  task automatic writeReg(input logic [15:0] a, input logic [7:0] d);
    ioAddr = a; ioWrData = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic readReg(input logic [15:0] a, output logic [7:0] d);
    ioAddr = a; ioRd = 1'b1;
    #2;
    d = ioRdData;
    ioRd = 1'b0;
    #1;
  endtask

  task automatic readWord(output logic [23:0] w);
    logic [7:0] b0, b1, b2;
    readReg(BASE, b0);
    readReg(BASE + 16'd1, b1);
    readReg(BASE + 16'd2, b2);
    w = {b2, b1, b0};
  endtask

  task automatic writeMaskWord(input logic [23:0] m);
    writeReg(BASE, m[7:0]);
    writeReg(BASE + 16'd1, m[15:8]);
    writeReg(BASE + 16'd2, m[23:16]);
    modelMask = m;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finishRun();
  end

  initial begin
    logic [23:0] w;
    logic [7:0] b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(cpuIrq == 1'b0, "R1 reset cpuIrq", cpuIrq, 0);
    setSrc('1);
    settle();
    check(cpuIrq == 1'b0, "R1 all masked after reset", cpuIrq, 0);
    // R4: raw state visible although masked
    readWord(w);
    check(w == 24'h07FFFF, "R4 raw readback while masked", w, 24'h07FFFF);
    // R7: reserved bits read zero
    readReg(BASE + 16'd2, b);
    check(b[7:3] == 5'd0, "R7 reserved read zero", b, {5'd0, b[2:0]});

    // R5/R6/R7: walking single source
    for (int s = 0; s < 19; s++) begin
      setSrc(19'd1 << s);
      settle();
      readWord(w);
      if (bitOf(s) < 8)       check(w == expWord(curSrc), "R5 byte0 layout", w, expWord(curSrc));
      else if (bitOf(s) < 16) check(w == expWord(curSrc), "R6 byte1 layout", w, expWord(curSrc));
      else                    check(w == expWord(curSrc), "R7 byte2 layout", w, expWord(curSrc));
    end

    // R3: enable all, then latency of the sync path (R9) and output (R8)
    setSrc('0);
    writeMaskWord(24'h000000);
    settle();
    check(cpuIrq == 1'b0, "R3 unmasked idle", cpuIrq, 0);
    usbIrq = 1'b1; curSrc[18] = 1'b1;
    @(negedge clk);
    readReg(BASE, b);
    check(b[6] == 1'b0, "R9 not visible after one edge", b[6], 0);
    @(negedge clk);
    readReg(BASE, b);
    check(b[6] == 1'b1, "R9 visible after two edges", b[6], 1);
    check(cpuIrq == 1'b0, "R9 cpuIrq not yet after two edges", cpuIrq, 0);
    @(negedge clk);
    check(cpuIrq == 1'b1, "R9 cpuIrq after three edges", cpuIrq, 1);

    // R8: mask write reaches cpuIrq one edge after it is stored
    writeReg(BASE, 8'h40);
    check(cpuIrq == 1'b1, "R8 cpuIrq one edge after mask store", cpuIrq, 1);
    @(negedge clk);
    check(cpuIrq == 1'b0, "R8 cpuIrq after mask", cpuIrq, 0);
    // R4: raw readback ignores mask
    readReg(BASE, b);
    check(b == 8'h40, "R4 masked source still reads raw", b, 8'h40);

    // R3: other bytes untouched; unmask USB again, mask byte 1 fully
    writeReg(BASE, 8'h00);
    writeReg(BASE + 16'd1, 8'hFF);
    settle();
    check(cpuIrq == 1'b1, "R3 byte1 write leaves byte0", cpuIrq, 1);

    // R2: neighbouring addresses are not decoded
    writeReg(BASE + 16'd3, 8'hFF);
    writeReg(BASE - 16'd1, 8'hFF);
    writeReg(16'h0004, 8'hFF);
    settle();
    check(cpuIrq == 1'b1, "R2 out-of-range writes ignored", cpuIrq, 1);
    readReg(BASE + 16'd3, b);
    check(b == 8'h00, "R2 out-of-range read zero", b, 0);
    readReg(BASE - 16'd1, b);
    check(b == 8'h00, "R2 below-range read zero", b, 0);

    // R7: reserved mask bits have no effect; byte2 source controls
    setSrc(19'd1 << 13);  // pin D of slot 1 -> word bit 16
    writeMaskWord(24'hFFFFFF);
    writeReg(BASE + 16'd2, 8'hF8);
    modelMask[23:16] = 8'hF8;
    settle();
    check(cpuIrq == 1'b1, "R7 reserved ones leave D1 enabled", cpuIrq, 1);
    writeReg(BASE + 16'd2, 8'h07);
    settle();
    check(cpuIrq == 1'b0, "R7 reserved zeros leave D1 masked", cpuIrq, 0);
    setSrc('0);
    writeReg(BASE + 16'd2, 8'h00);
    modelMask[23:16] = 8'h00;
    settle();
    check(cpuIrq == 1'b0, "R7 reserved zero write no irq", cpuIrq, 0);

    // Random rounds: R3, R4, R8
    for (int it = 0; it < 200; it++) begin
      int sel = $urandom_range(0, 4);
      logic [7:0] d = 8'($urandom);
      if (sel < 3) begin
        writeReg(BASE + 16'(sel), d);
        modelMask[sel*8 +: 8] = d;
      end else if (sel == 3) begin
        writeReg(BASE + 16'd3 + 16'($urandom_range(0, 8)), d);
      end
      if ($urandom_range(0, 3) == 0) setSrc('1);
      else setSrc(19'($urandom) & 19'($urandom));
      settle();
      readWord(w);
      check(w == expWord(curSrc), "R4 random readback", w, expWord(curSrc));
      check(cpuIrq == expIrq(curSrc, modelMask), "R8 random cpuIrq", cpuIrq,
            expIrq(curSrc, modelMask));
    end

    finishRun();
  end
endmodule